// File: doc/BRIEF.md
# Prioritized Interrupt Arbitration Controller

This block collects interrupt requests from three kinds of source: one non-maskable line, a set of external request lines and a set of on-chip peripheral lines. Each maskable source has a 4-bit priority level in a bank of software-writable registers. A level of zero switches the source off. From the sources that are pending and enabled, the block picks the one with the highest level. When levels are equal, a fixed order decides, and the source with the lower index wins. The non-maskable line is always at level 16 and beats every programmable source.

The winning level is compared with the processor's current mask level. If the winner clears the mask, the block raises a request toward the core. When the core acknowledges, the block stores the winner's own event code in a readable register. The codes are spaced 0x20 apart, so a handler can use the code directly as an offset into a jump table from one shared entry point. The block does not fetch vectors and does not take part in the core's exception entry.

Sources are numbered with the external lines first (index 0 to N_IRQ-1) and the peripheral lines after them. The priority registers, the field layout and the event register are reached through a plain address/data port with a write strobe.

Top module: `pic_top`

## Requirements
- R1: While `rst` is high, and on the edge where it is sampled, every priority field, `core_req`, `req_level` and `event_code` are cleared to zero.
- R2: A source whose level field is 0 never produces a request, even when its line is high.
- R3: Among enabled pending sources, the source with the highest level is the winner.
- R4: When pending sources share the highest level, the one with the lowest source index wins.
- R5: A high `nmi` wins over every other source, reports level 16 and is forwarded whatever `mask_lvl` holds.
- R6: A maskable winner is forwarded only when its level is strictly greater than `mask_lvl`.
- R7: `event_code` loads the forwarded winner's code only on a clock edge with `ack` high, and holds its value otherwise. The non-maskable code is 0x1C0, and maskable source i has the code 0x1C0 + 0x20*(i+1).
- R8: Register k (for k below the register count) holds the levels of sources 4k to 4k+3, with source 4k+j in bits [4j+3:4j]. A write lands on the strobed edge and reads back combinationally. The address equal to the register count reads `event_code`, and writes to that address have no effect.
- R9: `core_req` and `req_level` are registered one edge after their inputs. `req_level` is 0 whenever `core_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi | input | 1 | Non-maskable request line |
| irq | input | N_IRQ | External request lines, source indices 0 to N_IRQ-1 |
| periph | input | N_PER | Peripheral request lines, following the external lines |
| mask_lvl | input | 4 | Current processor mask level |
| ack | input | 1 | Core acknowledge; loads the event code |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational |
| core_req | output | 1 | Registered request to the core |
| req_level | output | 5 | Registered level of the forwarded winner |
| event_code | output | 12 | Code of the last acknowledged interrupt |

## Verification
The request outputs are due one edge after the line, level or mask change that causes them. A level write takes effect on its own edge, so a request that depends on it shows up one edge after the request lines rise. The event code changes on the edge that samples `ack`. Register reads are valid within the same cycle. The bench changes inputs one nanosecond after a rising edge and samples one nanosecond after the edge at which each result is due. Hold checks let several edges pass without `ack` before they compare.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LVL_W      = 4;
    localparam int FIELDS     = 4;
    localparam int REG_W      = LVL_W * FIELDS;
    localparam int IDX_W      = 8;
    localparam int CODE_W     = 12;
    localparam int OUT_LVL_W  = LVL_W + 1;
    localparam logic [CODE_W-1:0]    CODE_BASE = 12'h1C0;
    localparam logic [CODE_W-1:0]    CODE_STEP = 12'h020;
    localparam logic [OUT_LVL_W-1:0] NMI_LVL   = 5'd16;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        lvl_t             lvl;
    } winner_t;

    typedef struct packed {
        logic                 active;
        logic [OUT_LVL_W-1:0] level;
        logic [CODE_W-1:0]    code;
    } grant_t;

    function automatic logic [CODE_W-1:0] src_code(input logic [IDX_W-1:0] idx);
        return CODE_BASE + CODE_STEP * (CODE_W'(idx) + 12'd1);
    endfunction
endpackage

// File: rtl/pic_prio_bank.sv
module pic_prio_bank
    import pic_pkg::*;
#(
    parameter int N_SRC  = 40,
    parameter int N_REG  = 10,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rd_prio,
    output lvl_t              levels [N_SRC]
);
    logic [REG_W-1:0] bank_q [N_REG];

    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[r] <= '0;
            else if (wr_en && addr == ADDR_W'(r))
                bank_q[r] <= wdata;
        end
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_field
        assign levels[s] = bank_q[s / FIELDS][(s % FIELDS) * LVL_W +: LVL_W];
    end

    always_comb begin
        rd_prio = '0;
        for (int r = 0; r < N_REG; r++)
            if (addr == ADDR_W'(r)) rd_prio = bank_q[r];
    end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N_SRC = 40
) (
    input  logic [N_SRC-1:0] req,
    input  lvl_t             levels [N_SRC],
    output winner_t          win
);
    always_comb begin
        win = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i] && levels[i] != '0 && levels[i] >= win.lvl) begin
                win.valid = 1'b1;
                win.idx   = IDX_W'(i);
                win.lvl   = levels[i];
            end
        end
    end
endmodule

// File: rtl/pic_event_latch.sv
module pic_event_latch
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  grant_t            grant,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (ack && grant.active)
            code_q <= grant.code;
    end
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int N_PER  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 nmi,
    input  logic [N_IRQ-1:0]     irq,
    input  logic [N_PER-1:0]     periph,
    input  logic [LVL_W-1:0]     mask_lvl,
    input  logic                 ack,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic                 core_req,
    output logic [OUT_LVL_W-1:0] req_level,
    output logic [CODE_W-1:0]    event_code
);
    localparam int N_SRC = N_IRQ + N_PER;
    localparam int N_REG = (N_SRC + FIELDS - 1) / FIELDS;

    logic [N_SRC-1:0] src_req;
    lvl_t             levels [N_SRC];
    logic [REG_W-1:0] rd_prio;
    winner_t          win;
    grant_t           grant;

    assign src_req = {periph, irq};

    pic_prio_bank #(.N_SRC(N_SRC), .N_REG(N_REG), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rd_prio(rd_prio), .levels(levels)
    );

    pic_arbiter #(.N_SRC(N_SRC)) u_arb (
        .req(src_req), .levels(levels), .win(win)
    );

    always_comb begin
        grant = '0;
        if (nmi) begin
            grant.active = 1'b1;
            grant.level  = NMI_LVL;
            grant.code   = CODE_BASE;
        end else if (win.valid && win.lvl > mask_lvl) begin
            grant.active = 1'b1;
            grant.level  = {1'b0, win.lvl};
            grant.code   = src_code(win.idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_req  <= 1'b0;
            req_level <= '0;
        end else begin
            core_req  <= grant.active;
            req_level <= grant.level;
        end
    end

    pic_event_latch u_evt (
        .clk(clk), .rst(rst), .ack(ack), .grant(grant), .code_q(event_code)
    );

    always_comb begin
        if (addr == ADDR_W'(N_REG))
            rdata = {{(REG_W-CODE_W){1'b0}}, event_code};
        else
            rdata = rd_prio;
    end
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 nmi,
    input logic                 ack,
    input logic [LVL_W-1:0]     mask_lvl,
    input logic                 core_req,
    input logic [OUT_LVL_W-1:0] req_level,
    input logic [CODE_W-1:0]    event_code
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!core_req && event_code == '0));

    p_nmi_wins_r5: assert property (@(posedge clk) disable iff (rst)
        nmi |=> (core_req && req_level == NMI_LVL));

    p_mask_strict_r6: assert property (@(posedge clk) disable iff (rst)
        (core_req && req_level != NMI_LVL) |-> (req_level > {1'b0, $past(mask_lvl)}));

    p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
        !core_req |-> (req_level == '0));

    p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ack |=> $stable(event_code));
endmodule

bind pic_top pic_checker u_chk (
    .clk(clk), .rst(rst), .nmi(nmi), .ack(ack), .mask_lvl(mask_lvl),
    .core_req(core_req), .req_level(req_level), .event_code(event_code)
);

// File: tb/pic_top_test.sv
`timescale 1ns/1ps
module pic_top_test;
    localparam int N_IRQ = 8;
    localparam int N_PER = 32;
    localparam int N_SRC = N_IRQ + N_PER;
    localparam int EVT_ADDR = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi = 1'b0;
    logic [N_IRQ-1:0] irq = '0;
    logic [N_PER-1:0] periph = '0;
    logic [3:0]  mask_lvl = 4'd0;
    logic        ack = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        core_req;
    logic [4:0]  req_level;
    logic [11:0] event_code;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [3:0] shadow [N_SRC];

    always #10 clk = ~clk;

    pic_top uut (
        .clk(clk), .rst(rst), .nmi(nmi), .irq(irq), .periph(periph),
        .mask_lvl(mask_lvl), .ack(ack), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .core_req(core_req),
        .req_level(req_level), .event_code(event_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [11:0] code_of(input int s);
        return 12'h1C0 + 12'h20 * 12'(s + 1);
    endfunction

    task automatic bus_write(input int a, input logic [15:0] d);
        wr_en = 1'b1; addr = 4'(a); wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_level(input int s, input logic [3:0] l);
        logic [15:0] d;
        int r;
        shadow[s] = l;
        r = s / 4;
        for (int j = 0; j < 4; j++) d[4*j +: 4] = shadow[4*r + j];
        bus_write(r, d);
    endtask

    task automatic read_chk(input string req, input int a, input logic [15:0] exp);
        addr = 4'(a);
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 core_req", core_req, 0);
        chk("R1 req_level", req_level, 0);
        chk("R1 event_code", event_code, 0);
        read_chk("R1 prio reg0", 0, 16'h0000);
        read_chk("R1 prio reg9", 9, 16'h0000);
    endtask

    task automatic t_regs();
        bus_write(5, 16'hA5C3);
        read_chk("R8 readback", 5, 16'hA5C3);
        read_chk("R8 neighbour", 4, 16'h0000);
        bus_write(EVT_ADDR, 16'hFFFF);
        read_chk("R8 event addr ignores write", EVT_ADDR, 16'h0000);
        bus_write(5, 16'h0000);
        read_chk("R8 cleared", 5, 16'h0000);
    endtask

    task automatic t_level_zero();
        irq = 8'b0000_0100;
        step(); step();
        chk("R2 level0 no req", core_req, 0);
        chk("R9 idle level", req_level, 0);
        irq = '0;
    endtask

    task automatic t_highest();
        set_level(1, 4'd5);
        set_level(11, 4'd9);
        irq[1] = 1'b1; periph[3] = 1'b1;
        step();
        chk("R3 req", core_req, 1);
        chk("R3 level", req_level, 9);
        do_ack();
        chk("R7 code of src11", event_code, code_of(11));
    endtask

    task automatic t_tie();
        set_level(1, 4'd9);
        step();
        chk("R4 tie level", req_level, 9);
        do_ack();
        chk("R4 lower index wins", event_code, code_of(1));
    endtask

    task automatic t_mask();
        mask_lvl = 4'd9;
        step();
        chk("R6 equal mask blocks", core_req, 0);
        mask_lvl = 4'd8;
        step();
        chk("R6 above mask forwards", core_req, 1);
        chk("R9 registered level", req_level, 9);
    endtask

    task automatic t_nmi_hold();
        mask_lvl = 4'd15;
        nmi = 1'b1;
        step();
        chk("R5 nmi req", core_req, 1);
        chk("R5 nmi level", req_level, 16);
        step(); step();
        chk("R7 hold without ack", event_code, code_of(1));
        read_chk("R7 hold via port", EVT_ADDR, {4'h0, code_of(1)});
        do_ack();
        chk("R5 nmi code", event_code, 12'h1C0);
        nmi = 1'b0;
        step();
        chk("R6 masked after nmi", core_req, 0);
        chk("R7 holds after nmi drop", event_code, 12'h1C0);
    endtask

    initial begin
        for (int i = 0; i < N_SRC; i++) shadow[i] = 4'd0;
        step(); step();
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_regs();
        t_level_zero();
        t_highest();
        t_tie();
        t_mask();
        t_nmi_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule